// File: doc/BRIEF.md
# YUV to RGB888 Pixel Converter

This block turns luma/chroma pixels into 24-bit RGB pixels in a short fixed pipeline. Each pixel can arrive in one of two ways. In planar mode it comes as three separate 8-bit samples. In packed mode it comes as one 32-bit 4:2:2 word, which carries two luma samples and one shared chroma pair. The order of the four bytes inside a packed word is chosen per word by a 2-bit code. The unpacker sends the two pixels of a word one after the other.

Conversion uses fixed coefficients scaled by 1/1024. Chroma is taken relative to 128 and luma relative to 0. Each channel is floored and then clamped to 0..255. A per-pixel select bit decides whether the red or the blue component takes the upper byte of the output word.

Both sides are valid/ready streams. A stalled output freezes the whole pipeline.

Top module: `yuv_rgb_conv`

## Requirements
- R1: Offsets are subtracted before multiplying. Luma uses an offset of 0. Both chroma samples (u, v) use an offset of 128, so a pixel with u = v = 128 gives three equal channels.
- R2: With y = Y, u = U − 128 and v = V − 128, the channel sums are R = 1192·y + 1634·v, G = 1192·y − 401·u − 833·v and B = 1192·y + 2065·u. Each sum is arithmetically shifted right by 10 bits (floor).
- R3: After the shift, a negative result gives 0 and a result above 255 gives 255.
- R4: With in_bgr = 0, out_pix[23:16] = R, [15:8] = G and [7:0] = B. With in_bgr = 1, R and B change places: B is in [23:16] and R is in [7:0].
- R5: With in_packed = 0, each accepted transfer gives one pixel built from in_y, in_u and in_v.
- R6: With in_packed = 1, in_word is split according to in_order. The bytes are listed here from bit 31 down to bit 0: code 0 is V,Y1,U,Y0; code 1 is U,Y1,V,Y0; code 2 is Y1,V,Y0,U; code 3 is Y1,U,Y0,V. The word gives two pixels that share U and V: the Y0 pixel first, then the Y1 pixel. in_ready is low in the cycle after the word is accepted.
- R7: With out_ready high, a pixel accepted on clock edge N is on the output (out_valid high) after edge N+2, and not before.
- R8: While out_valid is high and out_ready is low, out_valid and out_pix hold and in_ready is low. out_valid only falls after a transfer.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_packed | input | 1 | 1: use in_word (packed 4:2:2); 0: use in_y/in_u/in_v |
| in_order | input | 2 | Byte order code for the packed word |
| in_bgr | input | 1 | Swap the R and B positions in the output |
| in_word | input | 32 | Packed 4:2:2 word |
| in_y | input | 8 | Planar luma sample |
| in_u | input | 8 | Planar blue-difference chroma |
| in_v | input | 8 | Planar red-difference chroma |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Output pixel taken |
| out_pix | output | 24 | RGB888 pixel |

## Verification
Planar vectors combine luma at 0, 16, 128, 235 and 255 with chroma at 0, 128 and 255, plus one mid-range pixel. Neutral chroma separates the luma-only path from the chroma terms. Chroma at its extremes drives each channel into the lower or upper clamp, which separates the floor from the saturation. One packed word is sent with each of the four byte-order codes. Each word has distinct bytes, so any swapped field changes the result. A stalled output with a second pixel waiting shows that nothing is lost or duplicated. A single isolated pixel pins the exact edge on which its result appears.

// File: rtl/yuv_rgb_conv.sv
module yuv_rgb_conv #(
  parameter int CW         = 8,
  parameter int FRAC       = 10,
  parameter int CHROMA_OFS = 128,
  parameter int K_Y        = 1192,
  parameter int K_RV       = 1634,
  parameter int K_GU       = 401,
  parameter int K_GV       = 833,
  parameter int K_BU       = 2065
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_packed,
  input  logic [1:0]      in_order,
  input  logic            in_bgr,
  input  logic [4*CW-1:0] in_word,
  input  logic [CW-1:0]   in_y,
  input  logic [CW-1:0]   in_u,
  input  logic [CW-1:0]   in_v,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [3*CW-1:0] out_pix
);
  localparam int PW = CW + FRAC + 4;
  localparam logic signed [PW-1:0] KY  = PW'(K_Y);
  localparam logic signed [PW-1:0] KRV = PW'(K_RV);
  localparam logic signed [PW-1:0] KGU = PW'(K_GU);
  localparam logic signed [PW-1:0] KGV = PW'(K_GV);
  localparam logic signed [PW-1:0] KBU = PW'(K_BU);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << CW) - 1);
  localparam logic signed [CW:0]   COFS = (CW+1)'(CHROMA_OFS);

  logic en;
  assign en = !out_valid || out_ready;

  // packed word field split
  logic [CW-1:0] b0, b1, b2, b3, w_y0, w_y1, w_u, w_v;
  assign {b3, b2, b1, b0} = in_word;
  always_comb begin
    case (in_order)
      2'd0:    begin w_y0 = b0; w_u = b1; w_y1 = b2; w_v = b3; end
      2'd1:    begin w_y0 = b0; w_v = b1; w_y1 = b2; w_u = b3; end
      2'd2:    begin w_u = b0; w_y0 = b1; w_v = b2; w_y1 = b3; end
      default: begin w_v = b0; w_y0 = b1; w_u = b2; w_y1 = b3; end
    endcase
  end

  // second pixel of a packed word waits here
  logic          pend_vld, pend_bgr;
  logic [CW-1:0] pend_y, pend_u, pend_v;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0; pend_bgr <= 1'b0;
      pend_y <= '0; pend_u <= '0; pend_v <= '0;
    end else if (en) begin
      if (pend_vld) pend_vld <= 1'b0;
      else if (in_valid && in_packed) begin
        pend_vld <= 1'b1; pend_bgr <= in_bgr;
        pend_y <= w_y1; pend_u <= w_u; pend_v <= w_v;
      end
    end
  end

  assign in_ready = en && !pend_vld;

  logic          src_vld, src_bgr;
  logic [CW-1:0] src_y, src_u, src_v;
  assign src_vld = pend_vld || in_valid;
  assign src_bgr = pend_vld ? pend_bgr : in_bgr;
  assign src_y   = pend_vld ? pend_y : (in_packed ? w_y0 : in_y);
  assign src_u   = pend_vld ? pend_u : (in_packed ? w_u  : in_u);
  assign src_v   = pend_vld ? pend_v : (in_packed ? w_v  : in_v);

  // stage 1: offsets
  logic              v1, bgr1;
  logic [CW-1:0]     y1;
  logic signed [CW:0] u1, c1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; bgr1 <= 1'b0; y1 <= '0; u1 <= '0; c1 <= '0;
    end else if (en) begin
      v1 <= src_vld; bgr1 <= src_bgr; y1 <= src_y;
      u1 <= $signed({1'b0, src_u}) - COFS;
      c1 <= $signed({1'b0, src_v}) - COFS;
    end
  end

  // stage 2: products
  logic                 v2, bgr2;
  logic signed [PW-1:0] p_y, p_rv, p_gu, p_gv, p_bu;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; bgr2 <= 1'b0;
      p_y <= '0; p_rv <= '0; p_gu <= '0; p_gv <= '0; p_bu <= '0;
    end else if (en) begin
      v2   <= v1; bgr2 <= bgr1;
      p_y  <= PW'($signed({1'b0, y1})) * KY;
      p_rv <= PW'(c1) * KRV;
      p_gu <= PW'(u1) * KGU;
      p_gv <= PW'(c1) * KGV;
      p_bu <= PW'(u1) * KBU;
    end
  end

  function automatic logic [CW-1:0] clip(input logic signed [PW-1:0] s);
    logic signed [PW-1:0] q;
    q = s >>> FRAC;
    if (q < 0)         clip = '0;
    else if (q > MAXV) clip = '1;
    else               clip = q[CW-1:0];
  endfunction

  logic [CW-1:0] ch_r, ch_g, ch_b;
  assign ch_r = clip(p_y + p_rv);
  assign ch_g = clip(p_y - p_gu - p_gv);
  assign ch_b = clip(p_y + p_bu);

  // stage 3: saturate and order
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_pix <= '0;
    end else if (en) begin
      out_valid <= v2;
      out_pix   <= bgr2 ? {ch_b, ch_g, ch_r} : {ch_r, ch_g, ch_b};
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));            // R8
  AST_NO_ACCEPT_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);                                // R8
  AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));                                // R8
  AST_PACK_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_packed |=> !in_ready);                      // R6
endmodule

// File: tb/yuv_rgb_conv_tb.sv
module yuv_rgb_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {bgr, y, u, v, expected}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 8'd0,   8'd128, 8'd128, 24'h000000},
    {1'b0, 8'd255, 8'd128, 8'd128, 24'hFFFFFF},
    {1'b0, 8'd128, 8'd128, 8'd128, 24'h959595},
    {1'b0, 8'd16,  8'd128, 8'd128, 24'h121212},
    {1'b0, 8'd235, 8'd128, 8'd128, 24'hFFFFFF},
    {1'b0, 8'd0,   8'd0,   8'd0,   24'h009A00},
    {1'b0, 8'd255, 8'd255, 8'd255, 24'hFF8FFF},
    {1'b0, 8'd255, 8'd0,   8'd255, 24'hFFF326},
    {1'b0, 8'd0,   8'd255, 8'd0,   24'h0036FF},
    {1'b0, 8'd128, 8'd0,   8'd255, 24'hFF5F00},
    {1'b0, 8'd0,   8'd255, 8'd255, 24'hCA00FF},
    {1'b0, 8'd100, 8'd90,  8'd200, 24'hE74827},
    {1'b1, 8'd100, 8'd90,  8'd200, 24'h2748E7},
    {1'b1, 8'd255, 8'd0,   8'd255, 24'h26F3FF}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_packed = 0, in_bgr = 0, out_ready = 1;
  logic [1:0] in_order = 0;
  logic [31:0] in_word = 0;
  logic [7:0] in_y = 0, in_u = 0, in_v = 0;
  logic in_ready, out_valid;
  logic [23:0] out_pix;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  yuv_rgb_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_packed(in_packed), .in_order(in_order), .in_bgr(in_bgr), .in_word(in_word),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix));

  function automatic int clamp8(int s);
    int q;
    q = s >>> 10;
    if (q < 0) return 0;
    if (q > 255) return 255;
    return q;
  endfunction

  function automatic logic [23:0] model(int y, int u, int v, bit bgr);
    int r, g, b;
    r = clamp8(1192*y + 1634*(v-128));
    g = clamp8(1192*y - 401*(u-128) - 833*(v-128));
    b = clamp8(1192*y + 2065*(u-128));
    return bgr ? {b[7:0], g[7:0], r[7:0]} : {r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(bit pk, logic [1:0] ord, bit bgr, logic [31:0] w,
                      logic [7:0] y, logic [7:0] u, logic [7:0] v);
    @(negedge clk);
    in_valid = 1; in_packed = pk; in_order = ord; in_bgr = bgr;
    in_word = w; in_y = y; in_u = u; in_v = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic get(output logic [23:0] pix);
    int n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    pix = out_pix;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] p, hold;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 out_valid after reset", {23'd0, out_valid}, 24'd0);
    check("R9 in_ready after reset", {23'd0, in_ready}, 24'd1);

    // R1 R2 R3 R4 R5: planar vector table
    for (int i = 0; i < NV; i++) begin
      send(0, 0, VEC[i][48], 0, VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
      get(p);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), p, VEC[i][23:0]);
    end
    check("R1 neutral chroma equal channels (model)", model(77, 128, 128, 0),
          {3{8'(clamp8(1192*77))}});

    // R7: exact latency
    @(negedge clk);
    in_valid = 1; in_packed = 0; in_bgr = 0; in_y = 128; in_u = 128; in_v = 128;
    @(negedge clk);
    in_valid = 0;
    check("R7 not valid after edge N", {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    check("R7 not valid after edge N+1", {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    check("R7 valid after edge N+2", {23'd0, out_valid}, 24'd1);
    check("R7 pixel", out_pix, 24'h959595);
    @(negedge clk);

    // R6: packed words, all byte orders
    for (int o = 0; o < 4; o++) begin
      logic [7:0] b3, b2, b1, b0, y0, y1, u, v;
      logic [23:0] q0, q1;
      {b3, b2, b1, b0} = 32'hC8_64_5A_10 + 32'h0301_0204 * o;
      case (o)
        0: begin y0 = b0; u = b1; y1 = b2; v = b3; end
        1: begin y0 = b0; v = b1; y1 = b2; u = b3; end
        2: begin u = b0; y0 = b1; v = b2; y1 = b3; end
        default: begin v = b0; y0 = b1; u = b2; y1 = b3; end
      endcase
      send(1, 2'(o), o == 3, {b3, b2, b1, b0}, 0, 0, 0);
      check($sformatf("R6 in_ready low after packed word order %0d", o),
            {23'd0, in_ready}, 24'd0);
      get(q0);
      get(q1);
      check($sformatf("R6 order %0d first pixel (Y0)", o), q0, model(y0, u, v, o == 3));
      check($sformatf("R6 order %0d second pixel (Y1)", o), q1, model(y1, u, v, o == 3));
    end

    // R8: backpressure
    @(negedge clk);
    out_ready = 0;
    send(0, 0, 0, 0, 100, 90, 200);
    while (!out_valid) @(negedge clk);
    hold = out_pix;
    in_valid = 1; in_packed = 0; in_bgr = 0; in_y = 0; in_u = 128; in_v = 128;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 out_valid held", {23'd0, out_valid}, 24'd1);
      check("R8 out_pix held", out_pix, hold);
      check("R8 in_ready low", {23'd0, in_ready}, 24'd0);
    end
    check("R8 held pixel value", hold, 24'hE74827);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    get(p);
    check("R8 pixel after stall", p, 24'h000000);
    @(negedge clk);
    check("R8 no duplicate", {23'd0, out_valid}, 24'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule